// File: doc/BRIEF.md
# Condition Register Field Move Unit

This block holds a 32-bit condition register made of eight 4-bit fields and carries out the field-oriented moves that a processor pipeline needs on it. It can merge a source value into any set of fields under an 8-bit mask, and it can write or read a single field named by a one-hot mask. It can also return the whole register zero-extended to 64 bits, load four fixed-point exception flags into a chosen field, and turn a chosen field into a -1 / +1 / 0 result.

An operation is presented on the input ports for one clock cycle. Any change to the condition register takes effect on the next rising edge. The 64-bit result is combinational and is computed from the register value held before that edge. Instruction decode and the register-file write of the result happen outside this block.

Top module: `crf_move_unit`

## Requirements
- R1: While `rstN` is low the condition register is cleared; after reset `crOut` reads 0, and with opcode 0 `resultOut` is 0.
- R2: Opcode 1 (many-field write) expands each mask bit k into a 4-bit group covering `crOut[4k+3:4k]`, so mask bit 7 covers the most significant field. The next register value is (`srcVal[31:0]` AND expanded mask) OR (register AND NOT expanded mask). `resultOut` is 0.
- R3: Opcode 2 (one-field write) copies `srcVal[4k+3:4k]` into `crOut[4k+3:4k]` only when exactly one mask bit k is set. With zero or several bits set the register is left unchanged. `resultOut` is 0 in both cases.
- R4: Opcode 3 (one-field read) with exactly one mask bit k set returns the register bits [4k+3:4k] in the same result bit positions and zeros elsewhere. With zero or several mask bits set it returns 0. The register is not changed.
- R5: Opcode 4 (whole read) returns 32 zero bits above the 32-bit register.
- R6: Opcode 5 (flag copy) writes {OV, OV32, CA, CA32}, OV as the most significant bit, into the field named by `fieldIdx`. Index 0 is `crOut[31:28]` and index 7 is `crOut[3:0]`. The other fields keep their values.
- R7: Opcode 6 (boolean) takes the field named by `fieldIdx` (same numbering as R6). It returns all ones if the field's top bit is set. Otherwise it returns 1 if the next bit is set, and otherwise 0.
- R8: Register updates land on the rising edge after the operation. The result reflects the register value before that edge. Opcodes 0 and 7 and all read opcodes leave the register unchanged; opcode 7 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opCode | input | 3 | Operation select (encoding in R2 to R8) |
| fieldMask | input | 8 | Field mask, bit k selects bits [4k+3:4k] |
| fieldIdx | input | 3 | Field index, 0 is the most significant field |
| srcVal | input | 64 | Source value; bits 31:0 feed the writes |
| xerOv | input | 1 | Overflow flag |
| xerOv32 | input | 1 | 32-bit overflow flag |
| xerCa | input | 1 | Carry flag |
| xerCa32 | input | 1 | 32-bit carry flag |
| resultOut | output | 64 | Combinational operation result |
| crOut | output | 32 | Current condition register |

## Verification
A register update and a result computed from the register can meet at the same edge. A write issued in one cycle must be visible to a read issued in the very next cycle, while the write's own cycle still shows the old register. The bench provokes this by issuing writes and reads back to back with no idle cycle between them. A scoreboard predicts both the result and the register from its own model and judges each against its expected pre-edge and post-edge values.

// File: rtl/crf_pkg.sv
package crf_pkg;
  localparam int FIELD_W = 4;

  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_WR_MANY = 3'd1,
    OP_WR_ONE  = 3'd2,
    OP_RD_ONE  = 3'd3,
    OP_RD_ALL  = 3'd4,
    OP_XER     = 3'd5,
    OP_BOOL    = 3'd6,
    OP_RSVD    = 3'd7
  } op_e;

  typedef struct packed {
    logic crWrMask;   // merge source under expanded mask
    logic crWrXer;    // load flags into indexed field
    logic resMasked;  // result = register under expanded mask
    logic resAll;     // result = whole register
    logic resBool;    // result = -1 / +1 / 0 from indexed field
  } strobe_t;
endpackage

// File: rtl/crf_ctrl.sv
module crf_ctrl
  import crf_pkg::*;
#(
  parameter int FIELDS = 8
) (
  input  logic [2:0]        opCode,
  input  logic [FIELDS-1:0] fieldMask,
  output strobe_t           strobes
);
  localparam int CNT_W = $clog2(FIELDS + 1);

  logic [CNT_W-1:0] setCount;
  logic             oneSet;

  always_comb begin
    setCount = '0;
    for (int k = 0; k < FIELDS; k++) begin
      setCount = setCount + CNT_W'(fieldMask[k]);
    end
  end

  assign oneSet = (setCount == CNT_W'(1));

  always_comb begin
    strobes = '0;
    unique case (op_e'(opCode))
      OP_WR_MANY: strobes.crWrMask  = 1'b1;
      OP_WR_ONE:  strobes.crWrMask  = oneSet;
      OP_RD_ONE:  strobes.resMasked = oneSet;
      OP_RD_ALL:  strobes.resAll    = 1'b1;
      OP_XER:     strobes.crWrXer   = 1'b1;
      OP_BOOL:    strobes.resBool   = 1'b1;
      default:    strobes = '0;
    endcase
  end
endmodule

// File: rtl/crf_datapath.sv
module crf_datapath
  import crf_pkg::*;
#(
  parameter int FIELDS = 8,
  parameter int DATA_W = 64
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    strobes,
  input  logic [FIELDS-1:0]          fieldMask,
  input  logic [$clog2(FIELDS)-1:0]  fieldIdx,
  input  logic [DATA_W-1:0]          srcVal,
  input  logic [FIELD_W-1:0]         xerNibble,
  output logic [DATA_W-1:0]          resultOut,
  output logic [FIELDS*FIELD_W-1:0]  crOut
);
  localparam int CR_W  = FIELDS * FIELD_W;
  localparam int IDX_W = $clog2(FIELDS);

  logic [CR_W-1:0]    crReg;
  logic [CR_W-1:0]    crNext;
  logic [CR_W-1:0]    maskWide;
  logic [CR_W-1:0]    xerMerged;
  logic [FIELDS-1:0]  idxHit;
  logic [FIELD_W-1:0] boolField;

  for (genvar k = 0; k < FIELDS; k++) begin : g_field
    assign maskWide[k*FIELD_W +: FIELD_W]  = {FIELD_W{fieldMask[k]}};
    assign idxHit[k]                       = (fieldIdx == IDX_W'(FIELDS - 1 - k));
    assign xerMerged[k*FIELD_W +: FIELD_W] = idxHit[k] ? xerNibble
                                                       : crReg[k*FIELD_W +: FIELD_W];
  end

  always_comb begin
    boolField = '0;
    for (int k = 0; k < FIELDS; k++) begin
      if (idxHit[k]) boolField = crReg[k*FIELD_W +: FIELD_W];
    end
  end

  always_comb begin
    crNext = crReg;
    if (strobes.crWrMask)
      crNext = (srcVal[CR_W-1:0] & maskWide) | (crReg & ~maskWide);
    else if (strobes.crWrXer)
      crNext = xerMerged;
  end

  always_ff @(posedge clk) begin
    if (!rstN) crReg <= '0;
    else       crReg <= crNext;
  end

  always_comb begin
    resultOut = '0;
    if (strobes.resMasked)
      resultOut = DATA_W'(crReg & maskWide);
    else if (strobes.resAll)
      resultOut = DATA_W'(crReg);
    else if (strobes.resBool) begin
      if (boolField[FIELD_W-1])      resultOut = '1;
      else if (boolField[FIELD_W-2]) resultOut = DATA_W'(1);
      else                           resultOut = '0;
    end
  end

  assign crOut = crReg;
endmodule

// File: rtl/crf_move_unit.sv
module crf_move_unit
  import crf_pkg::*;
#(
  parameter int FIELDS = 8,
  parameter int DATA_W = 64
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [2:0]                 opCode,
  input  logic [FIELDS-1:0]          fieldMask,
  input  logic [$clog2(FIELDS)-1:0]  fieldIdx,
  input  logic [DATA_W-1:0]          srcVal,
  input  logic                       xerOv,
  input  logic                       xerOv32,
  input  logic                       xerCa,
  input  logic                       xerCa32,
  output logic [DATA_W-1:0]          resultOut,
  output logic [FIELDS*FIELD_W-1:0]  crOut
);
  strobe_t strobes;

  crf_ctrl #(.FIELDS(FIELDS)) u_ctrl (
    .opCode    (opCode),
    .fieldMask (fieldMask),
    .strobes   (strobes)
  );

  crf_datapath #(.FIELDS(FIELDS), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .fieldMask (fieldMask),
    .fieldIdx  (fieldIdx),
    .srcVal    (srcVal),
    .xerNibble ({xerOv, xerOv32, xerCa, xerCa32}),
    .resultOut (resultOut),
    .crOut     (crOut)
  );
endmodule

// File: rtl/crf_move_chk.sv
module crf_move_chk
  import crf_pkg::*;
#(
  parameter int FIELDS = 8,
  parameter int DATA_W = 64
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [2:0]                 opCode,
  input logic [FIELDS-1:0]          fieldMask,
  input logic [$clog2(FIELDS)-1:0]  fieldIdx,
  input logic [DATA_W-1:0]          srcVal,
  input logic                       xerOv,
  input logic                       xerOv32,
  input logic                       xerCa,
  input logic                       xerCa32,
  input logic [DATA_W-1:0]          resultOut,
  input logic [FIELDS*FIELD_W-1:0]  crOut
);
  localparam int CR_W = FIELDS * FIELD_W;

  // R3
  wr_one_bad_mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == OP_WR_ONE && !$onehot(fieldMask)) |=> $stable(crOut));

  // R3
  wr_one_result_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == OP_WR_ONE) |-> (resultOut == '0));

  // R2
  wr_many_empty_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == OP_WR_MANY && fieldMask == '0) |=> $stable(crOut));

  // R4
  rd_one_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == OP_RD_ONE) |-> ((resultOut >> CR_W) == '0));

  // R5
  rd_all_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == OP_RD_ALL) |-> (resultOut == DATA_W'(crOut)));

  // R7
  bool_three_values_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == OP_BOOL) |->
      (resultOut == '1 || resultOut == DATA_W'(1) || resultOut == '0));

  // R8
  no_write_ops_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == OP_IDLE || opCode == OP_RD_ONE || opCode == OP_RD_ALL ||
     opCode == OP_BOOL || opCode == OP_RSVD) |=> $stable(crOut));
endmodule

bind crf_move_unit crf_move_chk #(.FIELDS(FIELDS), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/crf_move_unit_tb.sv
`timescale 1ns/1ps
module crf_move_unit_tb;
  import crf_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  opCode = 3'd0;
  logic [7:0]  fieldMask = 8'd0;
  logic [2:0]  fieldIdx = 3'd0;
  logic [63:0] srcVal = 64'd0;
  logic        xerOv = 1'b0, xerOv32 = 1'b0, xerCa = 1'b0, xerCa32 = 1'b0;
  logic [63:0] resultOut;
  logic [31:0] crOut;

  always #2.5 clk = ~clk;

  crf_move_unit u_dut (.*);

  typedef struct {
    logic [63:0] expRes;
    logic [31:0] expCr;
    string       tag;
  } item_t;

  item_t  sbQueue[$];
  int     compared = 0;
  int     mismatched = 0;
  logic [31:0] modelCr = 32'd0;
  bit     done = 1'b0;

  // Field n counted from the most significant end, big-endian style.
  function automatic logic [3:0] getFld(logic [31:0] cr, int n);
    return cr[31 - 4*n -: 4];
  endfunction

  function automatic int popCount(logic [7:0] m);
    int c = 0;
    for (int i = 0; i < 8; i++) c += m[i];
    return c;
  endfunction

  // Issue one operation, predict result (from pre-edge model) and post-edge register.
  task automatic doOp(input logic [2:0] op, input logic [7:0] msk, input logic [2:0] idx,
                      input logic [63:0] src, input logic [3:0] xer, input string tag);
    item_t it;
    logic [31:0] nextCr;
    logic [63:0] res;
    logic [3:0]  f;
    @(negedge clk);
    opCode = op; fieldMask = msk; fieldIdx = idx; srcVal = src;
    {xerOv, xerOv32, xerCa, xerCa32} = xer;
    nextCr = modelCr;
    res = 64'd0;
    case (op)
      3'd1: for (int n = 0; n < 8; n++)
              if (msk[7-n]) nextCr[31-4*n -: 4] = src[31-4*n -: 4];
      3'd2: if (popCount(msk) == 1)
              for (int n = 0; n < 8; n++)
                if (msk[7-n]) nextCr[31-4*n -: 4] = src[31-4*n -: 4];
      3'd3: if (popCount(msk) == 1)
              for (int n = 0; n < 8; n++)
                if (msk[7-n]) res[31-4*n -: 4] = getFld(modelCr, n);
      3'd4: res = {32'd0, modelCr};
      3'd5: nextCr[31-4*idx -: 4] = xer;
      3'd6: begin
              f = getFld(modelCr, idx);
              res = f[3] ? 64'hFFFF_FFFF_FFFF_FFFF : (f[2] ? 64'd1 : 64'd0);
            end
      default: ;
    endcase
    it.expRes = res; it.expCr = nextCr; it.tag = tag;
    sbQueue.push_back(it);
    modelCr = nextCr;
  endtask

  // Monitor: result checked just before the edge, register checked after it.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sbQueue.size() > 0) begin
        item_t it;
        it = sbQueue.pop_front();
        compared++;
        if (resultOut !== it.expRes) begin
          mismatched++;
          $display("FAIL %s result: actual %h expected %h", it.tag, resultOut, it.expRes);
        end
        @(posedge clk);
        #1;
        compared++;
        if (crOut !== it.expCr) begin
          mismatched++;
          $display("FAIL %s register: actual %h expected %h", it.tag, crOut, it.expCr);
        end
      end
    end
  end

  initial begin
    #20000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    compared++;
    if (crOut !== 32'd0) begin
      mismatched++;
      $display("FAIL R1 reset register: actual %h expected %h", crOut, 32'd0);
    end
    @(negedge clk);
    rstN = 1'b1;
    doOp(3'd0, 8'hFF, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 4'hF, "R1 idle after reset");

    // R2 many-field writes
    doOp(3'd1, 8'hFF, 3'd0, 64'hDEAD_BEEF_1234_5678, 4'h0, "R2 full mask");
    doOp(3'd1, 8'h00, 3'd0, 64'h0000_0000_FFFF_FFFF, 4'h0, "R2 empty mask");
    doOp(3'd1, 8'h81, 3'd0, 64'h0000_0000_A000_000B, 4'h0, "R2 edge fields");
    doOp(3'd1, 8'h5A, 3'd0, 64'h0000_0000_9C3E_71D4, 4'h0, "R2 mixed mask");

    // R3 one-field writes
    doOp(3'd2, 8'h10, 3'd0, 64'h0000_0000_0006_0000, 4'h0, "R3 one bit set");
    doOp(3'd2, 8'h00, 3'd0, 64'h0000_0000_FFFF_FFFF, 4'h0, "R3 no bit set");
    doOp(3'd2, 8'h30, 3'd0, 64'h0000_0000_FFFF_FFFF, 4'h0, "R3 two bits set");

    // R4 one-field reads (back to back with the writes above: R8)
    doOp(3'd3, 8'h10, 3'd0, 64'd0, 4'h0, "R4 read just-written field");
    doOp(3'd3, 8'h80, 3'd0, 64'd0, 4'h0, "R4 top field");
    doOp(3'd3, 8'h00, 3'd0, 64'd0, 4'h0, "R4 no bit set");
    doOp(3'd3, 8'h06, 3'd0, 64'd0, 4'h0, "R4 two bits set");

    // R5 whole read
    doOp(3'd4, 8'h00, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 4'h0, "R5 whole read");

    // R6 flag copies, each immediately followed by a read (R8)
    doOp(3'd5, 8'hFF, 3'd0, 64'd0, 4'b1000, "R6 OV into field 0");
    doOp(3'd4, 8'h00, 3'd0, 64'd0, 4'h0, "R8 read after flag copy");
    doOp(3'd5, 8'h00, 3'd7, 64'd0, 4'b0001, "R6 CA32 into field 7");
    doOp(3'd5, 8'h00, 3'd3, 64'd0, 4'b0110, "R6 OV32 and CA into field 3");
    doOp(3'd4, 8'h00, 3'd0, 64'd0, 4'h0, "R6 whole read after copies");

    // R7 boolean on prepared fields: 8, 4, C, 0, 2
    doOp(3'd1, 8'hFF, 3'd0, 64'h0000_0000_84C0_2000, 4'h0, "R7 prepare fields");
    doOp(3'd6, 8'h00, 3'd0, 64'd0, 4'h0, "R7 top bit set");
    doOp(3'd6, 8'h00, 3'd1, 64'd0, 4'h0, "R7 second bit set");
    doOp(3'd6, 8'h00, 3'd2, 64'd0, 4'h0, "R7 both bits set");
    doOp(3'd6, 8'h00, 3'd3, 64'd0, 4'h0, "R7 neither bit set");
    doOp(3'd6, 8'h00, 3'd4, 64'd0, 4'h0, "R7 only third bit set");

    // R8 idle and reserved opcodes leave register alone
    doOp(3'd7, 8'hFF, 3'd5, 64'hFFFF_FFFF_FFFF_FFFF, 4'hF, "R8 reserved opcode");
    doOp(3'd0, 8'hFF, 3'd5, 64'hFFFF_FFFF_FFFF_FFFF, 4'hF, "R8 idle opcode");
    doOp(3'd2, 8'h01, 3'd0, 64'h0000_0000_0000_0009, 4'h0, "R3 lowest field");
    doOp(3'd4, 8'h00, 3'd0, 64'd0, 4'h0, "R8 final read");

    @(negedge clk);
    opCode = 3'd0;
    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule